// File: doc/BRIEF.md
# TLB Global Invalidate Issue and Completion Controller

This block sits between instruction decode and the invalidate ports of the local TLB and of the remote cores in a multi-core system. A decoded global-invalidate command carries a register operand and a two-bit invalidate kind. The block first checks the configuration and coprocessor-enable conditions and raises an exception with a cause code when they fail. Otherwise it builds an invalidate message from the operand and the current memory-map identifier, then sends it to the local TLB and to every remote core in the same cycle.

A new broadcast is held back until the previous one has reached the global ordering point, which the interconnect signals with a pulse. Each target acknowledges its invalidation separately. A counter of outstanding acknowledgements lets a later sync command of the invalidate-completion subtype finish only once every earlier invalidation has been acknowledged. Sync commands of any other subtype complete at once. With zero remote cores the message goes to the local TLB only, and no ordering is applied.

Top module: `tinv_ctrl`

## Requirements
- R1: After reset, exc_valid, loc_valid, rem_valid and sync_done are low, and cmd_ready is high for a valid invalidate command.
- R2: An invalidate command with cfg_gi other than 2'b11 raises exception cause 2'b01 (reserved instruction). This check takes precedence over the coprocessor check.
- R3: With cfg_gi equal to 2'b11 and cp0_enabled low, the cause is 2'b10 (coprocessor unusable). This check takes precedence over the identifier-mode check.
- R4: With cfg_gi equal to 2'b11, cp0_enabled high and cfg_mmid_en low, the cause is 2'b01.
- R5: An exception is reported by exc_valid being high for exactly one cycle, the cycle after acceptance. No local or remote message is sent for it. An exceptional command is accepted even while broadcasts are blocked.
- R6: A good invalidate produces a one-cycle loc_valid and rem_valid in the cycle after acceptance. In that message, msg_vpn2 is operand bits [VPN2_MSB:13], msg_region is operand bits [63:62], msg_kind is the command's kind, and msg_mmid is cur_mmid zero-extended to MMID_W.
- R7: After a broadcast, cmd_ready stays low for further good invalidate commands until a rem_ordered pulse arrives. It returns high in the cycle after that pulse.
- R8: A sync command with subtype 5'h14 is stalled while any local or remote acknowledgement is outstanding. It is accepted once all are in, and sync_done pulses in the cycle after acceptance.
- R9: A sync command with any other subtype is accepted at once, even with acknowledgements outstanding, and pulses sync_done in the next cycle.
- R10: With NUM_REMOTE = 0, rem_valid never rises, back-to-back invalidates are accepted with no ordering wait, and only local acknowledgements are counted.
- R11: The identifier is sampled at acceptance, so successive invalidates carry their own cur_mmid values.
- R12: Each good invalidate adds NUM_REMOTE+1 outstanding acknowledgements. A further good invalidate is stalled when that addition would exceed MAX_OUT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| cmd_is_sync | input | 1 | 1 = sync command, 0 = global invalidate |
| cmd_inv_kind | input | 2 | Invalidate kind, passed through to the message |
| cmd_sync_stype | input | 5 | Sync subtype |
| cmd_operand | input | OP_W | Register operand of the invalidate |
| cfg_gi | input | 2 | Global-invalidate support field |
| cfg_mmid_en | input | 1 | Memory-map-identifier mode enabled |
| cp0_enabled | input | 1 | Coprocessor 0 access enabled |
| cur_mmid | input | MMID_IN_W | Current memory-map identifier |
| exc_valid | output | 1 | Exception pulse |
| exc_cause | output | 2 | 01 reserved instruction, 10 coprocessor unusable |
| loc_valid | output | 1 | Message to local TLB |
| rem_valid | output | 1 | Message broadcast to remote cores |
| msg_kind | output | 2 | Message invalidate kind |
| msg_vpn2 | output | VPN2_MSB-12 | Message page-pair number |
| msg_region | output | 2 | Message region bits |
| msg_mmid | output | MMID_W | Message identifier |
| loc_ack | input | 1 | Local TLB finished one invalidation |
| rem_ack | input | max(NUM_REMOTE,1) | Per remote core acknowledgement |
| rem_ordered | input | 1 | Previous broadcast reached the global ordering point |
| sync_done | output | 1 | Sync command complete |

## Verification
The hardest state to reach is a completion sync held up by a partial set of acknowledgements. The outstanding count has to be raised by a broadcast, and the local and remote acknowledgements then have to arrive in separate cycles, so that the stall can be seen after each one. The bench holds the sync valid and feeds the local acknowledgement, then two remote ones, then the last remote one. It checks that the stall lasts until that final acknowledgement. Capacity stall is reached by issuing three broadcasts without acknowledging any of them, with an ordering pulse after each one, so that only the counter limit blocks the fourth.

// File: rtl/tinv_pkg.sv
package tinv_pkg;
   localparam logic [1:0] CAUSE_RSVD    = 2'b01;
   localparam logic [1:0] CAUSE_COPUNUS = 2'b10;
   localparam logic [1:0] GI_SUPPORTED  = 2'b11;
   localparam logic [4:0] STYPE_INVDONE = 5'h14;
endpackage

// File: rtl/tinv_check.sv
module tinv_check #(
   parameter int OP_W      = 64,
   parameter int VPN2_MSB  = 39,
   parameter int MMID_W    = 16,
   parameter int MMID_IN_W = 12
) (
   input  logic [OP_W-1:0]      operand,
   input  logic [MMID_IN_W-1:0] cur_mmid,
   input  logic [1:0]           cfg_gi,
   input  logic                 mmid_en,
   input  logic                 cp0_en,
   output logic                 exc,
   output logic [1:0]           cause,
   output logic [VPN2_MSB-13:0] vpn2,
   output logic [1:0]           region,
   output logic [MMID_W-1:0]    mmid
);
   import tinv_pkg::*;

   // Exception priority: support field, then coprocessor, then id mode
   always_comb begin
      exc   = 1'b1;
      cause = CAUSE_RSVD;
      if (cfg_gi != GI_SUPPORTED) begin
         cause = CAUSE_RSVD;
      end else if (!cp0_en) begin
         cause = CAUSE_COPUNUS;
      end else if (!mmid_en) begin
         cause = CAUSE_RSVD;
      end else begin
         exc   = 1'b0;
         cause = 2'b00;
      end
   end

   assign vpn2   = operand[VPN2_MSB:13];
   assign region = operand[OP_W-1:OP_W-2];

   generate
      if (MMID_IN_W == MMID_W) begin : g_mmid_same
         assign mmid = cur_mmid;
      end else begin : g_mmid_ext
         assign mmid = {{(MMID_W-MMID_IN_W){1'b0}}, cur_mmid};
      end
   endgenerate
endmodule

// File: rtl/tinv_order.sv
module tinv_order #(
   parameter bit ENABLE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic issue,
   input  logic ordered,
   output logic blocked
);
   generate
      if (ENABLE) begin : g_order
         logic pend_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       pend_q <= 1'b0;
            else if (issue)   pend_q <= 1'b1;
            else if (ordered) pend_q <= 1'b0;
         end
         assign blocked = pend_q;

         // R7
         issue_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            issue |-> !pend_q)
            else $error("broadcast issued before ordering point");
      end else begin : g_no_order
         assign blocked = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/tinv_track.sv
module tinv_track #(
   parameter int NUM_REMOTE = 3,
   parameter int MAX_OUT    = 15,
   parameter int RACK_W     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic              loc_ack,
   input  logic [RACK_W-1:0] rem_ack,
   output logic              room,
   output logic              idle
);
   localparam int TARGETS = NUM_REMOTE + 1;
   localparam int CNT_W   = $clog2(MAX_OUT + 1);
   localparam logic [CNT_W:0] TGT_V = TARGETS[CNT_W:0];
   localparam logic [CNT_W:0] LIM_V = (MAX_OUT - TARGETS);
   localparam logic [CNT_W:0] MAX_V = MAX_OUT[CNT_W:0];

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   add_v, ack_sum, nxt;

   generate
      if (NUM_REMOTE > 0) begin : g_rem_count
         always_comb begin
            ack_sum = {{CNT_W{1'b0}}, loc_ack};
            for (int i = 0; i < NUM_REMOTE; i++)
               ack_sum = ack_sum + {{CNT_W{1'b0}}, rem_ack[i]};
         end
      end else begin : g_loc_count
         assign ack_sum = {{CNT_W{1'b0}}, loc_ack};
      end
   endgenerate

   assign add_v = issue ? TGT_V : '0;
   assign nxt   = {1'b0, cnt_q} + add_v - ack_sum;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= nxt[CNT_W-1:0];
   end

   assign room = ({1'b0, cnt_q} <= LIM_V);
   assign idle = (cnt_q == '0);

   // R12
   cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, cnt_q} <= MAX_V)
      else $error("outstanding count above limit");

   // R8
   ack_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_sum <= ({1'b0, cnt_q} + add_v))
      else $error("more acknowledgements than outstanding");
endmodule

// File: rtl/tinv_ctrl.sv
module tinv_ctrl #(
   parameter int OP_W       = 64,
   parameter int VPN2_MSB   = 39,
   parameter int MMID_W     = 16,
   parameter int MMID_IN_W  = 12,
   parameter int NUM_REMOTE = 3,
   parameter int MAX_OUT    = 15
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_valid,
   output logic                 cmd_ready,
   input  logic                 cmd_is_sync,
   input  logic [1:0]           cmd_inv_kind,
   input  logic [4:0]           cmd_sync_stype,
   input  logic [OP_W-1:0]      cmd_operand,
   input  logic [1:0]           cfg_gi,
   input  logic                 cfg_mmid_en,
   input  logic                 cp0_enabled,
   input  logic [MMID_IN_W-1:0] cur_mmid,
   output logic                 exc_valid,
   output logic [1:0]           exc_cause,
   output logic                 loc_valid,
   output logic                 rem_valid,
   output logic [1:0]           msg_kind,
   output logic [VPN2_MSB-13:0] msg_vpn2,
   output logic [1:0]           msg_region,
   output logic [MMID_W-1:0]    msg_mmid,
   input  logic                 loc_ack,
   input  logic [((NUM_REMOTE > 0) ? NUM_REMOTE : 1)-1:0] rem_ack,
   input  logic                 rem_ordered,
   output logic                 sync_done
);
   import tinv_pkg::*;

   localparam int  RACK_W  = (NUM_REMOTE > 0) ? NUM_REMOTE : 1;
   localparam int  VPN2_W  = VPN2_MSB - 12;
   localparam bit  HAS_REM = (NUM_REMOTE > 0);

   generate
      if (VPN2_MSB < 13 || VPN2_MSB > OP_W - 3) begin : g_bad_vpn
         $error("VPN2_MSB out of range");
      end
      if (MMID_IN_W > MMID_W || MMID_IN_W < 1) begin : g_bad_mmid
         $error("MMID_IN_W must be 1..MMID_W");
      end
      if (NUM_REMOTE < 0 || MAX_OUT < NUM_REMOTE + 1) begin : g_bad_cnt
         $error("MAX_OUT must cover one full broadcast");
      end
   endgenerate

   logic              chk_exc;
   logic [1:0]        chk_cause;
   logic [VPN2_W-1:0] chk_vpn2;
   logic [1:0]        chk_region;
   logic [MMID_W-1:0] chk_mmid;
   logic              ord_blocked, trk_room, trk_idle;
   logic              fire, inv_issue, inv_exc, sync_fire;

   tinv_check #(
      .OP_W(OP_W), .VPN2_MSB(VPN2_MSB), .MMID_W(MMID_W), .MMID_IN_W(MMID_IN_W)
   ) u_check (
      .operand(cmd_operand), .cur_mmid(cur_mmid), .cfg_gi(cfg_gi),
      .mmid_en(cfg_mmid_en), .cp0_en(cp0_enabled),
      .exc(chk_exc), .cause(chk_cause), .vpn2(chk_vpn2),
      .region(chk_region), .mmid(chk_mmid)
   );

   tinv_order #(.ENABLE(HAS_REM)) u_order (
      .clk(clk), .rst_n(rst_n), .issue(inv_issue && HAS_REM),
      .ordered(rem_ordered), .blocked(ord_blocked)
   );

   tinv_track #(.NUM_REMOTE(NUM_REMOTE), .MAX_OUT(MAX_OUT), .RACK_W(RACK_W)) u_track (
      .clk(clk), .rst_n(rst_n), .issue(inv_issue), .loc_ack(loc_ack),
      .rem_ack(rem_ack), .room(trk_room), .idle(trk_idle)
   );

   always_comb begin
      if (cmd_is_sync)
         cmd_ready = (cmd_sync_stype != STYPE_INVDONE) || trk_idle;
      else
         cmd_ready = chk_exc || (!ord_blocked && trk_room);
   end

   assign fire      = cmd_valid && cmd_ready;
   assign inv_issue = fire && !cmd_is_sync && !chk_exc;
   assign inv_exc   = fire && !cmd_is_sync && chk_exc;
   assign sync_fire = fire && cmd_is_sync;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loc_valid <= 1'b0;
         exc_valid <= 1'b0;
         exc_cause <= 2'b00;
         sync_done <= 1'b0;
      end else begin
         loc_valid <= inv_issue;
         exc_valid <= inv_exc;
         exc_cause <= inv_exc ? chk_cause : 2'b00;
         sync_done <= sync_fire;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msg_kind   <= '0;
         msg_vpn2   <= '0;
         msg_region <= '0;
         msg_mmid   <= '0;
      end else if (inv_issue) begin
         msg_kind   <= cmd_inv_kind;
         msg_vpn2   <= chk_vpn2;
         msg_region <= chk_region;
         msg_mmid   <= chk_mmid;
      end
   end

   generate
      if (HAS_REM) begin : g_bcast
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rem_valid <= 1'b0;
            else        rem_valid <= inv_issue;
         end

         // R6
         bcast_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
            loc_valid == rem_valid)
            else $error("local and remote messages out of step");
      end else begin : g_local_only
         assign rem_valid = 1'b0;
      end
   endgenerate

   // R5
   exc_no_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> (!loc_valid && !rem_valid))
      else $error("message sent with exception");

   // R8
   sync_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_fire && cmd_sync_stype == STYPE_INVDONE) |-> trk_idle)
      else $error("completion sync accepted with work outstanding");
endmodule

// File: tb/tb_tinv_ctrl.sv
`timescale 1ns/100ps
module tb_tinv_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0, v1 = 1'b0;
   logic        cmd_is_sync = 1'b0;
   logic [1:0]  cmd_inv_kind = 2'b00;
   logic [4:0]  cmd_sync_stype = 5'h00;
   logic [63:0] cmd_operand = '0;
   logic [1:0]  cfg_gi = 2'b11;
   logic        cfg_mmid_en = 1'b1, cp0_enabled = 1'b1;
   logic [11:0] cur_mmid = '0;
   logic        loc_ack = 1'b0, loc_ack1 = 1'b0;
   logic [2:0]  rem_ack = '0;
   logic        rem_ordered = 1'b0;

   logic        cmd_ready, exc_valid, loc_valid, rem_valid, sync_done;
   logic [1:0]  exc_cause, msg_kind, msg_region;
   logic [26:0] msg_vpn2;
   logic [15:0] msg_mmid;

   logic        ready1, exc1, loc1, rem1, done1;
   logic [1:0]  cause1, kind1, region1;
   logic [26:0] vpn1;
   logic [15:0] mmid1;

   int checks = 0, failures = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   tinv_ctrl dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_is_sync(cmd_is_sync), .cmd_inv_kind(cmd_inv_kind),
      .cmd_sync_stype(cmd_sync_stype), .cmd_operand(cmd_operand),
      .cfg_gi(cfg_gi), .cfg_mmid_en(cfg_mmid_en), .cp0_enabled(cp0_enabled),
      .cur_mmid(cur_mmid), .exc_valid(exc_valid), .exc_cause(exc_cause),
      .loc_valid(loc_valid), .rem_valid(rem_valid), .msg_kind(msg_kind),
      .msg_vpn2(msg_vpn2), .msg_region(msg_region), .msg_mmid(msg_mmid),
      .loc_ack(loc_ack), .rem_ack(rem_ack), .rem_ordered(rem_ordered),
      .sync_done(sync_done)
   );

   tinv_ctrl #(.NUM_REMOTE(0)) dut1 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(v1), .cmd_ready(ready1),
      .cmd_is_sync(cmd_is_sync), .cmd_inv_kind(cmd_inv_kind),
      .cmd_sync_stype(cmd_sync_stype), .cmd_operand(cmd_operand),
      .cfg_gi(cfg_gi), .cfg_mmid_en(cfg_mmid_en), .cp0_enabled(cp0_enabled),
      .cur_mmid(cur_mmid), .exc_valid(exc1), .exc_cause(cause1),
      .loc_valid(loc1), .rem_valid(rem1), .msg_kind(kind1),
      .msg_vpn2(vpn1), .msg_region(region1), .msg_mmid(mmid1),
      .loc_ack(loc_ack1), .rem_ack(1'b0), .rem_ordered(1'b0),
      .sync_done(done1)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic set_inv(input logic [1:0] kind, input logic [63:0] op,
                          input logic [11:0] id);
      cmd_is_sync  = 1'b0;
      cmd_inv_kind = kind;
      cmd_operand  = op;
      cur_mmid     = id;
   endtask

   task automatic pulse_ordered();
      rem_ordered = 1'b1;
      step();
      rem_ordered = 1'b0;
   endtask

   task automatic ack_all();
      loc_ack = 1'b1;
      rem_ack = 3'b111;
      step();
      loc_ack = 1'b0;
      rem_ack = 3'b000;
   endtask

   task automatic issue_good(input logic [11:0] id);
      set_inv(2'b01, 64'h0000_0012_3456_0000, id);
      cmd_valid = 1'b1;
      step();
      cmd_valid = 1'b0;
   endtask

   task automatic t_reset();
      set_inv(2'b00, '0, '0);
      #1;
      chk(cmd_ready == 1'b1, "R1 ready", cmd_ready, 1);
      chk({exc_valid, loc_valid, rem_valid, sync_done} == 4'b0, "R1 outputs idle",
          {exc_valid, loc_valid, rem_valid, sync_done}, 0);
   endtask

   task automatic exc_case(input logic [1:0] gi, input logic cp0, input logic men,
                           input logic [1:0] exp_cause, input string req);
      cfg_gi = gi; cp0_enabled = cp0; cfg_mmid_en = men;
      set_inv(2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 12'h123);
      cmd_valid = 1'b1;
      #1;
      chk(cmd_ready == 1'b1, {req, " exception accepted"}, cmd_ready, 1);
      step();
      cmd_valid = 1'b0;
      chk(exc_valid == 1'b1 && exc_cause == exp_cause, {req, " cause"},
          {exc_valid, exc_cause}, {1'b1, exp_cause});
      chk(!loc_valid && !rem_valid, "R5 no message on exception",
          {loc_valid, rem_valid}, 0);
      step();
      chk(exc_valid == 1'b0, "R5 one-cycle exception", exc_valid, 0);
      cfg_gi = 2'b11; cp0_enabled = 1'b1; cfg_mmid_en = 1'b1;
   endtask

   task automatic t_exceptions();
      exc_case(2'b10, 1'b0, 1'b0, 2'b01, "R2");
      exc_case(2'b00, 1'b1, 1'b1, 2'b01, "R2");
      exc_case(2'b11, 1'b0, 1'b0, 2'b10, "R3");
      exc_case(2'b11, 1'b1, 1'b0, 2'b01, "R4");
   endtask

   task automatic t_pack();
      logic [63:0] op;
      op = 64'hC000_00AB_CDEF_6000;
      set_inv(2'b11, op, 12'hA5C);
      cmd_valid = 1'b1;
      step();
      cmd_valid = 1'b0;
      cur_mmid = 12'h000;
      chk(loc_valid && rem_valid, "R6 both targets", {loc_valid, rem_valid}, 2'b11);
      chk(msg_vpn2 == op[39:13], "R6 vpn2", msg_vpn2, op[39:13]);
      chk(msg_region == op[63:62], "R6 region", msg_region, op[63:62]);
      chk(msg_kind == 2'b11, "R6 kind", msg_kind, 2'b11);
      chk(msg_mmid == 16'h0A5C, "R6 mmid zero-extended", msg_mmid, 16'h0A5C);
      step();
      chk(!loc_valid && !rem_valid, "R6 one-cycle message", {loc_valid, rem_valid}, 0);
   endtask

   task automatic t_order();
      set_inv(2'b01, 64'h0, 12'h001);
      #1;
      chk(cmd_ready == 1'b0, "R7 blocked after broadcast", cmd_ready, 0);
      step(); step();
      chk(cmd_ready == 1'b0, "R7 still blocked", cmd_ready, 0);
      cfg_gi = 2'b00;
      cmd_valid = 1'b1;
      #1;
      chk(cmd_ready == 1'b1, "R5 exception accepted while blocked", cmd_ready, 1);
      step();
      cmd_valid = 1'b0;
      cfg_gi = 2'b11;
      chk(exc_valid && !loc_valid && !rem_valid, "R5 exception while blocked",
          {exc_valid, loc_valid, rem_valid}, 3'b100);
      pulse_ordered();
      #1;
      chk(cmd_ready == 1'b1, "R7 released by ordering pulse", cmd_ready, 1);
   endtask

   task automatic t_sync();
      cmd_is_sync = 1'b1;
      cmd_sync_stype = 5'h00;
      cmd_valid = 1'b1;
      #1;
      chk(cmd_ready == 1'b1, "R9 other sync not stalled", cmd_ready, 1);
      step();
      cmd_valid = 1'b0;
      chk(sync_done == 1'b1, "R9 other sync done", sync_done, 1);
      cmd_sync_stype = 5'h14;
      cmd_valid = 1'b1;
      #1;
      chk(cmd_ready == 1'b0, "R8 sync stalled, 4 outstanding", cmd_ready, 0);
      loc_ack = 1'b1;
      step();
      loc_ack = 1'b0;
      #1;
      chk(cmd_ready == 1'b0 && !sync_done, "R8 stalled after local ack",
          {cmd_ready, sync_done}, 0);
      rem_ack = 3'b011;
      step();
      rem_ack = 3'b000;
      #1;
      chk(cmd_ready == 1'b0 && !sync_done, "R8 stalled with one remote left",
          {cmd_ready, sync_done}, 0);
      rem_ack = 3'b100;
      step();
      rem_ack = 3'b000;
      #1;
      chk(cmd_ready == 1'b1, "R8 released after last ack", cmd_ready, 1);
      step();
      cmd_valid = 1'b0;
      cmd_is_sync = 1'b0;
      chk(sync_done == 1'b1, "R8 sync done", sync_done, 1);
   endtask

   task automatic t_mmid();
      issue_good(12'h001);
      chk(msg_mmid == 16'h0001, "R11 first identifier", msg_mmid, 16'h0001);
      pulse_ordered();
      issue_good(12'hFFF);
      chk(msg_mmid == 16'h0FFF, "R11 second identifier", msg_mmid, 16'h0FFF);
      pulse_ordered();
      ack_all();
      ack_all();
   endtask

   task automatic t_room();
      for (int i = 0; i < 3; i++) begin
         issue_good(12'(i));
         pulse_ordered();
      end
      set_inv(2'b01, 64'h0, 12'h0);
      #1;
      chk(cmd_ready == 1'b0, "R12 stalled at 12 outstanding", cmd_ready, 0);
      ack_all();
      #1;
      chk(cmd_ready == 1'b1, "R12 room after acks", cmd_ready, 1);
      ack_all();
      ack_all();
      cmd_is_sync = 1'b1;
      cmd_sync_stype = 5'h14;
      #1;
      chk(cmd_ready == 1'b1, "R8 drained after capacity test", cmd_ready, 1);
      cmd_is_sync = 1'b0;
   endtask

   task automatic t_single();
      set_inv(2'b10, 64'h4000_0000_0000_2000, 12'h00F);
      v1 = 1'b1;
      step();
      chk(loc1 && !rem1, "R10 local only", {loc1, rem1}, 2'b10);
      cmd_operand = 64'h0;
      #1;
      chk(ready1 == 1'b1, "R10 no ordering wait", ready1, 1);
      step();
      v1 = 1'b0;
      chk(loc1 && !rem1, "R10 second local message", {loc1, rem1}, 2'b10);
      cmd_is_sync = 1'b1;
      cmd_sync_stype = 5'h14;
      #1;
      chk(ready1 == 1'b0, "R10 sync waits on local acks", ready1, 0);
      loc_ack1 = 1'b1;
      step();
      #1;
      chk(ready1 == 1'b0, "R10 one local ack left", ready1, 0);
      step();
      loc_ack1 = 1'b0;
      #1;
      chk(ready1 == 1'b1, "R10 sync released", ready1, 1);
      cmd_is_sync = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_exceptions();
      t_pack();
      t_order();
      t_sync();
      t_mmid();
      t_room();
      t_single();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule